// File: doc/BRIEF.md
# Open-Drain I2C Bit Engine

This block is the lowest layer of a single-master I2C controller. A sequencer above it hands it one byte-level command at a time: bus init with recovery, START, STOP, write a byte, or read a byte with a chosen acknowledge. The engine turns each command into a timed sequence of SCL and SDA levels. It reports the received byte, whether the target acknowledged a written byte, and whether the bus could not be freed during init. Clock stretching and arbitration are handled elsewhere.

Both lines are handled through an output-enable and an output-value pin. SDA is never driven high. Its data level stays at zero, and a low is made by enabling the output, while a high is made by releasing the line to the external pull-up. SCL is actively driven once init has run. Every level is held for a programmable half-period of `HALF_CYCLES` clock cycles.

Command codes on `cmd_op` are 0 = init, 1 = START, 2 = STOP, 3 = write byte, and 4 = read byte. Codes 5 to 7 are not defined.

Top module: `i2c_bit_engine`

## Requirements
- R1: Out of reset both lines are released (`scl_oe` = 0, `sda_oe` = 0). Whenever `sda_oe` is 1, `sda_o` is 0, so SDA can only be pulled low or released.
- R2: Init (code 0) drives SCL high with `scl_oe` = 1, releases SDA and waits 2 half-periods. If SDA then reads high, the command ends there without any SCL pulse and with `bus_stuck` = 0.
- R3: If SDA reads low after the init wait, the engine gives 8 SCL pulses of one half-period low and one half-period high (18 half-periods in total). It sets `bus_stuck` to 1 only if SDA is still low at the end. A later clean init clears it.
- R4: START (code 1) raises SCL, waits one half-period, pulls SDA low and waits one more. It lasts 2 half-periods and leaves SCL high and SDA low.
- R5: STOP (code 2) lowers SCL for a half-period, then pulls SDA low with SCL high for a half-period, then releases SDA for a half-period. It lasts 3 half-periods and leaves both lines high.
- R6: A byte write (code 3) shifts `cmd_wdata` out MSB first. Each bit is set up during a low half-period and held through the following high half-period. SDA never changes while SCL stays high. The write lasts 18 half-periods.
- R7: On the ninth SCL pulse of a write, SDA is released and sampled at the end of the high phase. `wr_acked` becomes 1 if SDA was low and 0 if it was high.
- R8: A byte read (code 4) first lowers SCL for a half-period before releasing SDA. It then samples 8 bits MSB first at the end of each high phase and presents them on `rd_data`. It lasts 19 half-periods, and SDA never changes while SCL stays high.
- R9: On the ninth SCL pulse of a read, the engine pulls SDA low only when `cmd_ack` was 1 at command acceptance. Otherwise it leaves SDA released.
- R10: A command is accepted when `cmd_valid` is 1 and `busy` is 0. `busy` then stays high until the command ends, and `done` pulses for exactly one cycle as `busy` falls. `cmd_valid` while busy is ignored.
- R11: Command codes 5 to 7 are ignored. `busy` and `done` stay 0 and the line controls keep their values.
- R12: `rd_data`, `wr_acked` and `bus_stuck` change only in the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 init, 1 START, 2 STOP, 3 write, 4 read) |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ack | input | 1 | For reads: 1 to acknowledge the byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command end |
| rd_data | output | 8 | Last byte read |
| wr_acked | output | 1 | Last written byte was acknowledged |
| bus_stuck | output | 1 | Init could not free SDA |
| scl_oe | output | 1 | SCL output enable |
| scl_o | output | 1 | SCL output level |
| sda_oe | output | 1 | SDA output enable (1 pulls SDA low) |
| sda_o | output | 1 | SDA output level, held at 0 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bound checker watches several properties on every cycle: the single-cycle `done` pulse and its tie to the fall of `busy`, acceptance and rejection of command codes, the rule that SDA is only ever pulled low, SDA steadiness while SCL is high inside byte transfers, SCL being driven after init, and the result outputs holding still between completions. The bench scenarios are the only evidence for command durations in half-periods, bit order on the wire, ack detection against a responding target, the master acknowledge on reads, and the recovery decision. For recovery, the bench releases a stuck SDA after each possible number of SCL pulses, from one to more than eight.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_INIT  = 3'd0,
        OP_START = 3'd1,
        OP_STOP  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    typedef enum logic [4:0] {
        S_IDLE,
        S_INIT_WAIT,
        S_INIT_LO,
        S_INIT_HI,
        S_START_A,
        S_START_B,
        S_STOP_A,
        S_STOP_B,
        S_STOP_C,
        S_WR_LO,
        S_WR_HI,
        S_WR_ACKLO,
        S_WR_ACKHI,
        S_RD_PRE,
        S_RD_LO,
        S_RD_HI,
        S_RD_ACKLO,
        S_RD_ACKHI
    } st_e;

    typedef struct packed {
        logic scl_oe;
        logic scl_o;
        logic sda_oe;
        logic sda_o;
    } pins_t;

    localparam pins_t PINS_RESET = '{scl_oe: 1'b0, scl_o: 1'b1, sda_oe: 1'b0, sda_o: 1'b0};

    // Line levels applied on entry to a phase; each phase then lasts its wait.
    function automatic pins_t enter_pins(input st_e s, input pins_t cur,
                                         input logic tx_bit, input logic ack_req);
        pins_t p;
        p = cur;
        case (s)
            S_INIT_WAIT: begin
                p.scl_oe = 1'b1;
                p.scl_o  = 1'b1;
                p.sda_o  = 1'b0;
                p.sda_oe = 1'b0;
            end
            S_INIT_LO:  p.scl_o = 1'b0;
            S_INIT_HI:  p.scl_o = 1'b1;
            S_START_A:  p.scl_o = 1'b1;
            S_START_B:  p.sda_oe = 1'b1;
            S_STOP_A:   p.scl_o = 1'b0;
            S_STOP_B: begin
                p.sda_oe = 1'b1;
                p.scl_o  = 1'b1;
            end
            S_STOP_C:   p.sda_oe = 1'b0;
            S_WR_LO: begin
                p.scl_o  = 1'b0;
                p.sda_oe = ~tx_bit;
            end
            S_WR_HI:    p.scl_o = 1'b1;
            S_WR_ACKLO: p.scl_o = 1'b0;
            S_WR_ACKHI: begin
                p.sda_oe = 1'b0;
                p.scl_o  = 1'b1;
            end
            S_RD_PRE:   p.scl_o = 1'b0;
            S_RD_LO: begin
                p.scl_o  = 1'b0;
                p.sda_oe = 1'b0;
            end
            S_RD_HI:    p.scl_o = 1'b1;
            S_RD_ACKLO: begin
                p.scl_o  = 1'b0;
                p.sda_oe = ack_req;
            end
            S_RD_ACKHI: p.scl_o = 1'b1;
            default:    p = cur;
        endcase
        return p;
    endfunction

    function automatic logic op_known(input logic [2:0] op);
        return op <= OP_LAST;
    endfunction

endpackage

// File: rtl/i2cbe_halfper.sv
module i2cbe_halfper #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/i2cbe_shreg.sv
module i2cbe_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            cnt <= '0;
        end else if (load) begin
            q   <= load_data;
            cnt <= '0;
        end else if (shift) begin
            q   <= {q[W-2:0], shift_in};
            cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/i2cbe_seq.sv
module i2cbe_seq
    import i2cbe_pkg::*;
#(
    parameter int HALF_CYCLES = 250,
    parameter int CNT_W       = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic              sda_in,
    input  logic              expire,
    input  logic [BYTE_W-1:0] sh_q,
    input  logic              sh_last,
    output logic              tm_load,
    output logic [CNT_W-1:0]  tm_val,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_data,
    output logic              sh_shift,
    output pins_t             pins,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    output logic              acked,
    output logic              stuck
);
    localparam logic [CNT_W-1:0] ONE_HALF = CNT_W'(HALF_CYCLES - 1);
    localparam logic [CNT_W-1:0] TWO_HALF = CNT_W'(2 * HALF_CYCLES - 1);

    st_e  st, ns;
    logic txb, fin, err_set, err_val, ack_set, ack_val, rd_set, ack_q;

    always_comb begin
        ns       = st;
        tm_load  = 1'b0;
        tm_val   = ONE_HALF;
        sh_load  = 1'b0;
        sh_data  = cmd_wdata;
        sh_shift = 1'b0;
        txb      = sh_q[BYTE_W-2];
        fin      = 1'b0;
        err_set  = 1'b0;
        err_val  = 1'b0;
        ack_set  = 1'b0;
        ack_val  = 1'b0;
        rd_set   = 1'b0;
        if (st == S_IDLE) begin
            if (cmd_valid) begin
                case (cmd_op)
                    OP_INIT: begin
                        ns     = S_INIT_WAIT;
                        tm_val = TWO_HALF;
                    end
                    OP_START: ns = S_START_A;
                    OP_STOP:  ns = S_STOP_A;
                    OP_WRITE: begin
                        ns      = S_WR_LO;
                        sh_load = 1'b1;
                        txb     = cmd_wdata[BYTE_W-1];
                    end
                    OP_READ: begin
                        ns      = S_RD_PRE;
                        sh_load = 1'b1;
                        sh_data = '0;
                    end
                    default: ns = S_IDLE;
                endcase
                tm_load = (ns != S_IDLE);
            end
        end else if (expire) begin
            tm_load = 1'b1;
            case (st)
                S_INIT_WAIT: begin
                    if (sda_in) begin
                        fin     = 1'b1;
                        err_set = 1'b1;
                        err_val = 1'b0;
                    end else begin
                        ns      = S_INIT_LO;
                        sh_load = 1'b1;
                    end
                end
                S_INIT_LO: ns = S_INIT_HI;
                S_INIT_HI: begin
                    if (sh_last) begin
                        fin     = 1'b1;
                        err_set = 1'b1;
                        err_val = ~sda_in;
                    end else begin
                        sh_shift = 1'b1;
                        ns       = S_INIT_LO;
                    end
                end
                S_START_A: ns = S_START_B;
                S_START_B: fin = 1'b1;
                S_STOP_A:  ns = S_STOP_B;
                S_STOP_B:  ns = S_STOP_C;
                S_STOP_C:  fin = 1'b1;
                S_WR_LO:   ns = S_WR_HI;
                S_WR_HI: begin
                    if (sh_last) begin
                        ns = S_WR_ACKLO;
                    end else begin
                        sh_shift = 1'b1;
                        ns       = S_WR_LO;
                    end
                end
                S_WR_ACKLO: ns = S_WR_ACKHI;
                S_WR_ACKHI: begin
                    fin     = 1'b1;
                    ack_set = 1'b1;
                    ack_val = ~sda_in;
                end
                S_RD_PRE: ns = S_RD_LO;
                S_RD_LO:  ns = S_RD_HI;
                S_RD_HI: begin
                    sh_shift = 1'b1;
                    ns       = sh_last ? S_RD_ACKLO : S_RD_LO;
                end
                S_RD_ACKLO: ns = S_RD_ACKHI;
                S_RD_ACKHI: begin
                    fin    = 1'b1;
                    rd_set = 1'b1;
                end
                default: fin = 1'b1;
            endcase
            if (fin) begin
                ns      = S_IDLE;
                tm_load = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            pins  <= PINS_RESET;
            done  <= 1'b0;
            rdata <= '0;
            acked <= 1'b0;
            stuck <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            st   <= ns;
            done <= fin;
            if (ns != st) begin
                pins <= enter_pins(ns, pins, txb, ack_q);
            end
            if (st == S_IDLE && cmd_valid && cmd_op == OP_READ) begin
                ack_q <= cmd_ack;
            end
            if (err_set) stuck <= err_val;
            if (ack_set) acked <= ack_val;
            if (rd_set)  rdata <= sh_q;
        end
    end

    assign busy = (st != S_IDLE);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2cbe_pkg::*;
#(
    parameter int HALF_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    output logic              wr_acked,
    output logic              bus_stuck,
    output logic              scl_oe,
    output logic              scl_o,
    output logic              sda_oe,
    output logic              sda_o,
    input  logic              sda_i
);
    localparam int CNT_W = $clog2(2 * HALF_CYCLES) + 1;

    logic              tm_load, expire, sh_load, sh_shift, sh_last;
    logic [CNT_W-1:0]  tm_val;
    logic [BYTE_W-1:0] sh_data, sh_q;
    pins_t             pins;

    i2cbe_halfper #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .expire   (expire)
    );

    i2cbe_shreg #(.W(BYTE_W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_data (sh_data),
        .shift     (sh_shift),
        .shift_in  (sda_i),
        .q         (sh_q),
        .last      (sh_last)
    );

    i2cbe_seq #(.HALF_CYCLES(HALF_CYCLES), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .cmd_ack   (cmd_ack),
        .sda_in    (sda_i),
        .expire    (expire),
        .sh_q      (sh_q),
        .sh_last   (sh_last),
        .tm_load   (tm_load),
        .tm_val    (tm_val),
        .sh_load   (sh_load),
        .sh_data   (sh_data),
        .sh_shift  (sh_shift),
        .pins      (pins),
        .busy      (busy),
        .done      (done),
        .rdata     (rd_data),
        .acked     (wr_acked),
        .stuck     (bus_stuck)
    );

    assign scl_oe = pins.scl_oe;
    assign scl_o  = pins.scl_o;
    assign sda_oe = pins.sda_oe;
    assign sda_o  = pins.sda_o;
endmodule

// File: rtl/i2cbe_chk.sv
module i2cbe_chk
    import i2cbe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic [BYTE_W-1:0] rd_data,
    input logic              wr_acked,
    input logic              bus_stuck,
    input logic              scl_oe,
    input logic              scl_o,
    input logic              sda_oe,
    input logic              sda_o
);
    logic [2:0] op_q;
    logic       scl_hi;

    assign scl_hi = scl_oe && scl_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= 3'd0;
        end else if (cmd_valid && !busy) begin
            op_q <= cmd_op;
        end
    end

    p_reset_release_r1: assert property (@(posedge clk) rst |=> (!scl_oe && !sda_oe))
        else $error("R1 lines not released after reset");

    p_sda_only_low_r1: assert property (@(posedge clk) disable iff (rst) sda_oe |-> !sda_o)
        else $error("R1 SDA driven high");

    p_init_drives_scl_r2: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_INIT) |-> (scl_oe && scl_o))
        else $error("R2 SCL not driven high after init");

    // Also covers R8: bytes read keep SDA steady while SCL is high.
    p_sda_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && (op_q == OP_WRITE || op_q == OP_READ) && scl_hi && $past(scl_hi))
        |-> $stable(sda_oe))
        else $error("R6 SDA moved while SCL high");

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done)
        else $error("R10 done longer than one cycle");

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)))
        else $error("R10 done not at end of busy");

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && op_known(cmd_op)) |=> busy)
        else $error("R10 command not accepted");

    p_ignore_op_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !op_known(cmd_op)) |=> (!busy && !done))
        else $error("R11 undefined code started a command");

    p_results_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rd_data) && $stable(wr_acked) && $stable(bus_stuck)))
        else $error("R12 result moved without done");
endmodule

bind i2c_bit_engine i2cbe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .wr_acked  (wr_acked),
    .bus_stuck (bus_stuck),
    .scl_oe    (scl_oe),
    .scl_o     (scl_o),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o)
);

// File: tb/i2c_bit_engine_tb_top.sv
`timescale 1ns/1ps
module i2c_bit_engine_tb_top;
    import i2cbe_pkg::*;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic       cmd_ack = 1'b0;
    logic       busy, done, wr_acked, bus_stuck, scl_oe, scl_o, sda_oe, sda_o;
    logic [7:0] rd_data;
    logic       scl_bus, sda_bus, sda_i, stuck;

    always #2 clk = ~clk;

    // Target side: mode 0 idle, 1 write, 2 read, 3 init with held SDA
    int         mode = 0;
    int         cmd_seq = 0;
    int         seq_seen = 0;
    int         rc = 0;
    int         falls = 0;
    int         stuck_n = 0;
    logic       tgt_drive = 1'b0;
    logic       tgt_ack = 1'b0;
    logic [7:0] rbyte = 8'd0;
    logic [7:0] seen = 8'd0;
    logic       mast_ack = 1'b0;
    logic       scl_prev = 1'b1;
    int         glitch = 0;
    logic       g_scl = 1'b1;
    logic       g_sda = 1'b1;
    int         tests = 0;
    int         fails = 0;

    assign scl_bus = scl_oe ? scl_o : 1'b1;
    assign stuck   = (mode == 3) && (falls < stuck_n);
    assign sda_bus = ((sda_oe && !sda_o) || tgt_drive || stuck) ? 1'b0 : 1'b1;
    assign sda_i   = sda_bus;

    i2c_bit_engine #(.HALF_CYCLES(HALF)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .cmd_ack   (cmd_ack),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .wr_acked  (wr_acked),
        .bus_stuck (bus_stuck),
        .scl_oe    (scl_oe),
        .scl_o     (scl_o),
        .sda_oe    (sda_oe),
        .sda_o     (sda_o),
        .sda_i     (sda_i)
    );

    always @(scl_bus or cmd_seq) begin
        if (cmd_seq != seq_seen) begin
            seq_seen = cmd_seq;
            rc = 0;
            falls = 0;
        end
        if (scl_bus !== scl_prev) begin
            if (scl_bus) begin
                if (mode == 1 && rc < 8) seen[7-rc] = sda_bus;
                if (mode == 2 && rc == 8) mast_ack = !sda_bus;
                rc = rc + 1;
            end else begin
                falls = falls + 1;
                if (mode == 1)      tgt_drive = (rc == 8) ? tgt_ack : 1'b0;
                else if (mode == 2) tgt_drive = (rc < 8) ? !rbyte[7-rc] : 1'b0;
                else                tgt_drive = 1'b0;
            end
            scl_prev = scl_bus;
        end
    end

    always @(negedge clk) begin
        if (busy && (mode == 1 || mode == 2) && g_scl && scl_bus && (sda_bus != g_sda))
            glitch = glitch + 1;
        g_scl = scl_bus;
        g_sda = sda_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [7:0] wd, input logic ack,
                       input int md, input int poke, output int cyc);
        @(negedge clk);
        mode      = md;
        cmd_seq   = cmd_seq + 1;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = wd;
        cmd_ack   = ack;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (poke != 0 && cyc == poke) begin
                cmd_valid = 1'b1;
                cmd_op    = OP_READ;
            end else begin
                cmd_valid = 1'b0;
            end
        end while (!done && cyc < 3000);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        int g0;
        bit ok;
        logic [7:0] keep;
        logic keep_ack;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 reset releases lines", {scl_oe, sda_oe}, 0);
        chk(!busy && !done, "R10 idle after reset", {busy, done}, 0);

        // R11: undefined codes
        for (int op = 5; op < 8; op++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_op    = 3'(op);
            @(negedge clk);
            cmd_valid = 1'b0;
            ok = 1'b1;
            for (int i = 0; i < 3; i++) begin
                if (busy || done) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R11 undefined code ignored", op, 0);
            chk(!scl_oe && !sda_oe && scl_o && !sda_o, "R11 lines unchanged",
                {scl_oe, scl_o, sda_oe, sda_o}, 4);
        end

        // R2: clean init
        stuck_n = 0;
        run(OP_INIT, 8'd0, 1'b0, 3, 0, cyc);
        chk(cyc == 2 * HALF, "R2 clean init length", cyc, 2 * HALF);
        chk(falls == 0, "R2 no SCL pulses", falls, 0);
        chk(!bus_stuck, "R2 no stuck flag", bus_stuck, 0);
        chk(scl_oe && scl_o && !sda_oe, "R2 lines after init",
            {scl_oe, scl_o, sda_oe}, 6);

        // R3: recovery sweep
        for (int k = 1; k <= 9; k++) begin
            stuck_n = k;
            run(OP_INIT, 8'd0, 1'b0, 3, 0, cyc);
            chk(cyc == 18 * HALF, "R3 recovery length", cyc, 18 * HALF);
            chk(falls == 8, "R3 eight pulses", falls, 8);
            chk(bus_stuck == (k > 8), "R3 stuck decision", bus_stuck, (k > 8));
        end
        stuck_n = 0;
        run(OP_INIT, 8'd0, 1'b0, 3, 0, cyc);
        chk(!bus_stuck, "R3 clean init clears flag", bus_stuck, 0);

        // R4: START
        run(OP_START, 8'd0, 1'b0, 0, 0, cyc);
        chk(cyc == 2 * HALF, "R4 start length", cyc, 2 * HALF);
        chk(scl_bus && !sda_bus, "R4 start end levels", {scl_bus, sda_bus}, 2);

        // R6/R7: every byte written
        for (int b = 0; b < 256; b++) begin
            tgt_ack = b[0] ^ b[5];
            g0 = glitch;
            run(OP_WRITE, 8'(b), 1'b0, 1, 0, cyc);
            chk(cyc == 18 * HALF, "R6 write length", cyc, 18 * HALF);
            chk(seen == 8'(b), "R6 bits MSB first", seen, b);
            chk(glitch == g0, "R6 SDA steady with SCL high", glitch - g0, 0);
            chk(wr_acked == tgt_ack, "R7 ack detection", wr_acked, tgt_ack);
        end

        // R8/R9: every byte read
        for (int b = 0; b < 256; b++) begin
            rbyte = 8'(b);
            g0 = glitch;
            run(OP_READ, 8'd0, b[2], 2, 0, cyc);
            chk(cyc == 19 * HALF, "R8 read length", cyc, 19 * HALF);
            chk(rd_data == 8'(b), "R8 read data", rd_data, b);
            chk(glitch == g0, "R8 SDA steady with SCL high", glitch - g0, 0);
            chk(mast_ack == b[2], "R9 master ack choice", mast_ack, b[2]);
        end

        // R12: results held between completions
        keep = rd_data;
        tgt_ack = 1'b1;
        run(OP_WRITE, 8'h5A, 1'b0, 1, 0, cyc);
        chk(rd_data == keep, "R12 read data held over write", rd_data, keep);
        keep_ack = wr_acked;
        run(OP_START, 8'd0, 1'b0, 0, 0, cyc);
        chk(wr_acked == keep_ack, "R12 ack held over start", wr_acked, keep_ack);

        // R10: request while busy is ignored
        tgt_ack = 1'b1;
        run(OP_WRITE, 8'hC3, 1'b0, 1, 10, cyc);
        chk(cyc == 18 * HALF, "R10 busy request ignored", cyc, 18 * HALF);
        chk(seen == 8'hC3, "R10 byte intact", seen, 8'hC3);
        @(negedge clk);
        chk(!busy, "R10 idle after done", busy, 0);

        // R5: STOP
        run(OP_STOP, 8'd0, 1'b0, 0, 0, cyc);
        chk(cyc == 3 * HALF, "R5 stop length", cyc, 3 * HALF);
        chk(scl_bus && sda_bus && !sda_oe, "R5 stop end levels",
            {scl_bus, sda_bus, sda_oe}, 6);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule